// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines, remembers each one that has asserted, and raises a single interrupt output toward the processor. The request lines are asynchronous and edge-triggered. Each line is synchronized and then edge-detected. A rising edge sets a sticky pending bit in the request register. Level 0 has the highest priority and level 7 the lowest. The output is raised only when the best pending level outranks every level already being serviced. This means a handler for a high level is never interrupted by a lower one.

When the processor acknowledges, the best eligible pending level leaves the request register and enters the in-service register. Software closes a handler with a non-specific end-of-interrupt command, which retires the highest-priority in-service level. A small four-address register port carries these commands. A command written to address 0 also chooses whether later reads at address 0 return the request register or the in-service register.

A poll command turns the next read, at any of the four addresses, into a status byte. The byte holds a pending flag and the best eligible level. That read also serves as the acknowledge, so software can service interrupts without a hardware acknowledge cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on irqIn[n] sets request bit n three clock edges later. The bit stays set until that level is acknowledged. A line held high after its acknowledge does not set the bit again until it falls and rises.
- R2: intOut is high exactly when at least one request bit is set and the lowest-numbered set request bit is lower than every set in-service bit. An empty in-service register blocks nothing.
- R3: A cycle with intAck high while intOut is high clears the lowest-numbered set request bit and sets the same bit in the in-service register. A cycle with intAck high while intOut is low changes nothing.
- R4: Writing a command with bits 7:6 = 01 at address 0 is a non-specific end-of-interrupt. It clears the lowest-numbered set bit of the in-service register.
- R5: Writing a command with bits 7:6 = 10 and bit 2 = 0 at address 0 selects what ordinary reads at address 0 return. Bit 0 = 0 selects the request register and bit 0 = 1 selects the in-service register. Ordinary reads at addresses 1 to 3 return 0.
- R6: Writing a command with bits 7:6 = 10 and bit 2 = 1 at address 0 arms poll mode. The next read at any address then returns the poll byte. Bit 7 of the poll byte equals intOut. Bits 2:0 hold the lowest-numbered pending level when bit 7 is 1 and are 0 otherwise. Bits 6:3 are always 0.
- R7: A poll read acknowledges in the same way as R3 and disarms poll mode, so the following read is an ordinary one. A poll command leaves the read selection of R5 unchanged.
- R8: After reset, both registers are zero, intOut is low, and reads at address 0 return the request register.
- R9: Read data appears on busRdData in the cycle after busRdEn is sampled high. It holds until the next read. Writes at addresses 1 to 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Asynchronous request lines, bit n is level n |
| busAddr | input | 2 | Register port address |
| busWrEn | input | 1 | Command write strobe |
| busWrData | input | 8 | Command byte |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data |
| intAck | input | 1 | Processor acknowledge pulse |
| intOut | output | 1 | Interrupt request toward the processor |

## Verification
The hardest situation to reach is a nested one. Several levels must be in service at once, with lower levels pending behind them, while a poll read or an end-of-interrupt arrives. The poll byte and intOut then depend on both registers together. The stimulus reaches this with directed sequences that stack two levels into service before retiring them one at a time. It follows these with a long seeded random mix of pulses on random line sets, acknowledges, end-of-interrupts, selections and polls. The random part builds and unwinds nesting many times, and a bench-side model predicts every read and every intOut sample.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] CmdOpEoi  = 2'b01;
  localparam logic [1:0] CmdOpRsel = 2'b10;
  localparam int CmdPollBit = 2;
  localparam int CmdSelBit  = 0;

  typedef struct packed {
    logic ackReq;
    logic eoi;
    logic rdCapture;
    logic rdPoll;
    logic rdSelIsr;
    logic rdAddrZero;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int Width  = 8,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [Width-1:0] asyncIn,
  output logic [Width-1:0] risePulse
);
  for (genvar b = 0; b < Width; b++) begin : g_bit
    logic [Stages:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[Stages-1:0], asyncIn[b]};
    end
    // compare the newest synchronized sample with the one before it
    assign risePulse[b] = chain[Stages-1] & ~chain[Stages];
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int AddrW = 2,
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrEn,
  input  logic [DataW-1:0] busWrData,
  input  logic             busRdEn,
  input  logic             intAck,
  output ctrlStrb_t        strb
);
  logic pollMode;
  logic selIsr;
  logic cmdValid, rselCmd, pollCmd;

  assign cmdValid = busWrEn && (busAddr == '0);
  assign rselCmd  = cmdValid && (busWrData[DataW-1 -: 2] == CmdOpRsel);
  assign pollCmd  = rselCmd && busWrData[CmdPollBit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pollMode <= 1'b0;
      selIsr   <= 1'b0;
    end else begin
      if (pollCmd)      pollMode <= 1'b1;
      else if (busRdEn) pollMode <= 1'b0;
      if (rselCmd && !busWrData[CmdPollBit]) selIsr <= busWrData[CmdSelBit];
    end
  end

  always_comb begin
    strb            = '0;
    strb.rdPoll     = busRdEn && pollMode;
    strb.ackReq     = intAck || strb.rdPoll;
    strb.eoi        = cmdValid && (busWrData[DataW-1 -: 2] == CmdOpEoi);
    strb.rdCapture  = busRdEn;
    strb.rdSelIsr   = selIsr;
    strb.rdAddrZero = (busAddr == '0);
  end

  // R6: a poll command arms poll mode for the next cycle
  a_r6_poll_arms: assert property (@(posedge clk) disable iff (!rst_n)
    pollCmd |=> pollMode);
  // R7: any read without a new poll command leaves poll mode disarmed
  a_r7_poll_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && !pollCmd) |=> !pollMode);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NumLevels = 8,
  parameter int DataW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NumLevels-1:0] reqRise,
  input  ctrlStrb_t            strb,
  output logic                 intOut,
  output logic [DataW-1:0]     rdData
);
  localparam int LvlW = $clog2(NumLevels);

  logic [NumLevels-1:0] irr, isr;
  logic [NumLevels-1:0] ackMask, eoiMask;
  logic                 pendValid, svcValid, eligible;
  logic [LvlW-1:0]      pendLvl, svcLvl;
  logic [DataW-1:0]     pollByte, regByte;

  // fixed priority: lowest index wins, scan from the top down
  always_comb begin
    pendValid = 1'b0;
    pendLvl   = '0;
    svcValid  = 1'b0;
    svcLvl    = '0;
    for (int i = NumLevels - 1; i >= 0; i--) begin
      if (irr[i]) begin
        pendValid = 1'b1;
        pendLvl   = i[LvlW-1:0];
      end
      if (isr[i]) begin
        svcValid = 1'b1;
        svcLvl   = i[LvlW-1:0];
      end
    end
  end

  assign eligible = pendValid && (!svcValid || (pendLvl < svcLvl));
  assign intOut   = eligible;

  always_comb begin
    ackMask = '0;
    eoiMask = '0;
    if (strb.ackReq && eligible) ackMask[pendLvl] = 1'b1;
    if (strb.eoi && svcValid)    eoiMask[svcLvl]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= (irr & ~ackMask) | reqRise;
      isr <= (isr & ~eoiMask) | ackMask;
    end
  end

  always_comb begin
    pollByte          = '0;
    pollByte[DataW-1] = eligible;
    if (eligible) pollByte[LvlW-1:0] = pendLvl;
    regByte = '0;
    if (strb.rdAddrZero) regByte[NumLevels-1:0] = strb.rdSelIsr ? isr : irr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdData <= '0;
    else if (strb.rdCapture) rdData <= strb.rdPoll ? pollByte : regByte;
  end

  // R1: request bits only drop through an acknowledge
  a_r1_request_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.ackReq |=> ((irr & $past(irr)) == $past(irr)));
  // R3: an accepted acknowledge adds exactly one in-service level
  a_r3_ack_adds_service: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackReq && intOut && !strb.eoi) |=> ($countones(isr) == $past($countones(isr)) + 1));
  // R4: an end-of-interrupt retires exactly one level
  a_r4_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eoi && !strb.ackReq && (isr != '0)) |=> ($countones(isr) == $past($countones(isr)) - 1));
  // R6: reserved poll bits read back as zero
  a_r6_poll_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdPoll |=> (rdData[DataW-2:LvlW] == '0));
  // R9: read data holds between reads
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdCapture |=> $stable(rdData));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NumLevels = 8,
  parameter int AddrW     = 2,
  parameter int DataW     = 8,
  parameter int SyncDepth = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NumLevels-1:0] irqIn,
  input  logic [AddrW-1:0]     busAddr,
  input  logic                 busWrEn,
  input  logic [DataW-1:0]     busWrData,
  input  logic                 busRdEn,
  output logic [DataW-1:0]     busRdData,
  input  logic                 intAck,
  output logic                 intOut
);
  ctrlStrb_t            strb;
  logic [NumLevels-1:0] reqRise;

  irq_sync_edge #(.Width(NumLevels), .Stages(SyncDepth)) sync_i (
    .clk(clk), .rst_n(rst_n), .asyncIn(irqIn), .risePulse(reqRise)
  );

  irq_ctrl #(.AddrW(AddrW), .DataW(DataW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .intAck(intAck), .strb(strb)
  );

  irq_datapath #(.NumLevels(NumLevels), .DataW(DataW)) dp_i (
    .clk(clk), .rst_n(rst_n), .reqRise(reqRise), .strb(strb),
    .intOut(intOut), .rdData(busRdData)
  );
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [7:0] irqIn;
  logic [1:0] busAddr;
  logic       busWrEn, busRdEn, intAck, intOut;
  logic [7:0] busWrData, busRdData;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .intAck(intAck), .intOut(intOut)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mIrr, mIsr;
  logic       mSelIsr;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int eligLvl(input logic [7:0] r, input logic [7:0] s);
    int p = lowest(r);
    if (p < 8 && p < lowest(s)) return p;
    return -1;
  endfunction

  function automatic logic [7:0] pollExp(input logic [7:0] r, input logic [7:0] s);
    int l = eligLvl(r, s);
    if (l < 0) return 8'h00;
    return 8'h80 | l[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkInt(input string req);
    check(req, {7'b0, intOut}, {7'b0, eligLvl(mIrr, mIsr) >= 0});
  endtask

  task automatic modelAck();
    int l = eligLvl(mIrr, mIsr);
    if (l >= 0) begin
      mIrr[l] = 1'b0;
      mIsr[l] = 1'b1;
    end
  endtask

  task automatic pulse(input logic [7:0] mask);
    @(negedge clk) irqIn = mask;
    repeat (4) @(negedge clk);
    irqIn = 8'h00;
    repeat (3) @(negedge clk);
    mIrr = mIrr | mask;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a == 2'd0) begin
      if (d[7:6] == 2'b01) begin
        int s = lowest(mIsr);
        if (s < 8) mIsr[s] = 1'b0;
      end else if (d[7:6] == 2'b10 && !d[2]) mSelIsr = d[0];
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic ack();
    @(negedge clk) intAck = 1'b1;
    @(negedge clk) intAck = 1'b0;
    modelAck();
  endtask

  task automatic pollRead(input string req, input logic [1:0] a);
    logic [7:0] d, e;
    e = pollExp(mIrr, mIsr);
    wr(2'd0, 8'h84);
    rd(a, d);
    check(req, d, e);
    modelAck();
  endtask

  task automatic plainRead(input string req, input logic [1:0] a);
    logic [7:0] d;
    rd(a, d);
    check(req, d, (a != 2'd0) ? 8'h00 : (mSelIsr ? mIsr : mIrr));
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [7:0] d;
    irqIn = 0; busAddr = 0; busWrEn = 0; busWrData = 0; busRdEn = 0; intAck = 0;
    mIrr = 0; mIsr = 0; mSelIsr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    void'($urandom(32'd20240611));

    // R8 reset state
    checkInt("R8 intOut after reset");
    plainRead("R8 request register after reset", 2'd0);
    wr(2'd0, 8'h81);
    plainRead("R8 in-service register after reset", 2'd0);
    wr(2'd0, 8'h80);

    // R1 timing: the bit is set three edges after the line rises
    @(negedge clk) irqIn = 8'h28;
    @(negedge clk);
    @(negedge clk);
    check("R1 not yet set after two edges", {7'b0, intOut}, 8'h00);
    @(negedge clk);
    check("R1 set after three edges", {7'b0, intOut}, 8'h01);
    irqIn = 8'h00;
    mIrr = 8'h28;
    repeat (3) @(negedge clk);
    plainRead("R1 R5 request register", 2'd0);
    ack();
    checkInt("R2 level 5 blocked by level 3 in service");
    wr(2'd0, 8'h81);
    plainRead("R3 R5 in-service after ack", 2'd0);
    plainRead("R5 address 1 reads zero", 2'd1);
    ack();
    plainRead("R3 ack ignored while intOut low", 2'd0);
    pulse(8'h01);
    checkInt("R2 higher level interrupts");
    ack();
    plainRead("R3 nested in-service", 2'd0);
    wr(2'd0, 8'h40);
    plainRead("R4 eoi clears highest-priority level", 2'd0);
    wr(2'd2, 8'h40);
    plainRead("R9 write at address 2 ignored", 2'd0);
    wr(2'd0, 8'h40);
    checkInt("R2 level 5 eligible after eoi");

    // R6 R7 poll
    pollRead("R6 poll byte with level 5", 2'd3);
    plainRead("R7 poll mode cleared after one read", 2'd3);
    plainRead("R7 poll read acknowledged and selection kept", 2'd0);
    wr(2'd0, 8'h40);
    pollRead("R6 poll byte with nothing pending", 2'd1);

    // R1 held level does not retrigger
    @(negedge clk) irqIn = 8'h04;
    repeat (4) @(negedge clk);
    mIrr[2] = 1'b1;
    ack();
    wr(2'd0, 8'h40);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h80);
    plainRead("R1 held line does not set again", 2'd0);
    checkInt("R1 intOut stays low while line held");
    @(negedge clk) irqIn = 8'h00;
    repeat (3) @(negedge clk);

    // R9 read data holds
    rd(2'd0, d);
    pulse(8'h10);
    check("R9 read data holds between reads", busRdData, d);

    for (int it = 0; it < 500; it++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: pulse(8'($urandom_range(0, 255)));
        1: ack();
        2: wr(2'd0, 8'h40);
        3: begin
          wr(2'd0, {7'b1000000, 1'($urandom_range(0, 1))});
          plainRead("R5 random selected read", 2'd0);
        end
        4: pollRead("R6 R7 random poll", 2'($urandom_range(0, 3)));
        default: plainRead("R5 random plain read", 2'($urandom_range(0, 3)));
      endcase
      checkInt("R2 random intOut");
    end
    finish();
  end
endmodule